// File: doc/BRIEF.md
# ECC Error Status and Log Capture

This block watches the single-bit (correctable) and multi-bit (uncorrectable) error pulses that a memory read path raises, and records each kind in a sticky status flag. Alongside each pulse it receives the column, row, bank, rank and syndrome of the failing access. A log register keeps one of these address and syndrome sets, chosen by an asymmetric lock: a correctable error may be replaced by a later uncorrectable one, but an uncorrectable error holds the log until software clears its flag.

Software reaches the block through a small register port. The flags clear on a write of 1 and survive a warm reset; only the power-good reset clears them and the log. A command register picks which flags may raise a system-error message. A device-wide enable gates every message. The block turns each enabled flag's set event into a one-cycle request pulse.

The lock is held in a three-state machine. `LK_OPEN` means neither flag is set. `LK_SOFT` means only the single-bit flag is set. `LK_HARD` means the multi-bit flag is set. Its transitions are:
- OPEN to SOFT on a single-bit error.
- OPEN to HARD on a multi-bit error.
- SOFT to HARD on a multi-bit error.
- SOFT to OPEN when the single-bit flag is cleared and no new single-bit error arrives.
- HARD to SOFT when the multi-bit flag is cleared and the single-bit flag stays or becomes set.
- HARD to OPEN when the multi-bit flag is cleared and the single-bit flag ends up clear.

Top module: `ecc_err_recorder`

## Requirements
- R1: After a power-good reset, with warm reset applied too, these all read 0: the status register, the command register and every log field. `serr_req_o` is low.
- R2: Status bit 0 is the single-bit flag and bit 1 is the multi-bit flag, both at address 0. A set flag stays set until software writes 1 to that bit at address 0. Writing 0 to a bit leaves it unchanged.
- R3: A warm reset (`rst_n` low, `pwrgood_n` high) leaves the flags and the log unchanged and returns the command register to 0.
- R4: A single-bit error while both flags are clear sets bit 0 and loads the log with that error's column, row, bank, rank and syndrome.
- R5: A single-bit error while only bit 0 is set leaves the log unchanged.
- R6: A multi-bit error while only bit 0 is set sets bit 1 and overwrites the log with its own fields.
- R7: While bit 1 is set, no error of either kind changes the log. A single-bit error in that state still sets bit 0.
- R8: Single-bit and multi-bit errors in the same cycle set both flags and load the log. The block then behaves as locked by the multi-bit error.
- R9: A write of 1 to a flag in the same cycle as a new error of that kind leaves the flag set and raises no new message. The log decision in that cycle follows the lock state at the start of the cycle.
- R10: `serr_req_o` pulses high for exactly one cycle, in the cycle after an error sets a previously clear flag, but only if the command bit for that flag (bit 0 single, bit 1 multi) is 1 and `dev_serr_en_i` is high. An error that finds its flag already set raises no pulse.
- R11: The register map is:
  - address 1: the command register. Bits [1:0] are read/write and the upper bits read 0.
  - address 2: logged column. Address 3: logged row.
  - address 4: logged bank in the low bits, with rank immediately above it.
  - address 5: logged syndrome.
  - Writes to addresses 2 to 5 have no effect, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| pwrgood_n | input | 1 | Power-good reset, active low, synchronous; clears everything |
| sb_err_i | input | 1 | Single-bit correctable error pulse |
| mb_err_i | input | 1 | Multi-bit uncorrectable error pulse |
| err_col_i | input | COL_W | Column of the failing access |
| err_row_i | input | ROW_W | Row of the failing access |
| err_bank_i | input | BANK_W | Bank of the failing access |
| err_rank_i | input | RANK_W | Rank of the failing access |
| err_syn_i | input | SYN_W | Error syndrome |
| dev_serr_en_i | input | 1 | Device-wide system-error message enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| serr_req_o | output | 1 | One-cycle system-error message request |

## Verification
The hardest situation to reach from the ports is the cycle where a write of 1 to a flag meets a fresh error of the same kind. It matters most when the lock is in the HARD state with the single-bit flag also set. The return to SOFT and the loss-free clear can only be seen there.

The stimulus walks a vector table that drives the error pulse and the status write on the same clock edge. It builds the lock up step by step so that each lock state has both flags in the required combination. After every step it reads the flags and the log back through the register port.

// File: rtl/ecc_rec_pkg.sv
package ecc_rec_pkg;

    typedef enum logic [1:0] {
        LK_OPEN = 2'd0,
        LK_SOFT = 2'd1,
        LK_HARD = 2'd2
    } lock_state_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_SB   = 0;
    localparam int FLAG_MB   = 1;

    localparam int A_STATUS  = 0;
    localparam int A_CMD     = 1;
    localparam int A_LOG_COL = 2;
    localparam int A_LOG_ROW = 3;
    localparam int A_LOG_BR  = 4;
    localparam int A_LOG_SYN = 5;

endpackage

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         pwrgood_n,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!pwrgood_n) flag_q[i] <= 1'b0;
            else            flag_q[i] <= evt_i[i] | (flag_q[i] & ~clr_i[i]);
        end

        assign rise_o[i] = evt_i[i] & ~flag_q[i];

        // R2
        flag_sticky_chk: assert property (@(posedge clk)
            disable iff (!pwrgood_n || !rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/ecc_log_lock_fsm.sv
module ecc_log_lock_fsm
    import ecc_rec_pkg::*;
(
    input  logic        clk,
    input  logic        pwrgood_n,
    input  logic        sb_evt_i,
    input  logic        mb_evt_i,
    input  logic        sb_clr_i,
    input  logic        mb_clr_i,
    input  logic        sb_flag_i,
    output lock_state_e state_o,
    output logic        load_o
);
    lock_state_e state_q, state_d;
    logic        sb_next;

    always_ff @(posedge clk) begin
        if (!pwrgood_n) state_q <= LK_OPEN;
        else            state_q <= state_d;
    end

    always_comb begin
        sb_next = (sb_flag_i & ~sb_clr_i) | sb_evt_i;
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (mb_evt_i)      state_d = LK_HARD;
                else if (sb_evt_i) state_d = LK_SOFT;
            end
            LK_SOFT: begin
                if (mb_evt_i)                   state_d = LK_HARD;
                else if (sb_clr_i && !sb_evt_i) state_d = LK_OPEN;
            end
            LK_HARD: begin
                if (mb_clr_i && !mb_evt_i) state_d = sb_next ? LK_SOFT : LK_OPEN;
            end
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        unique case (state_q)
            LK_OPEN: load_o = sb_evt_i | mb_evt_i;
            LK_SOFT: load_o = mb_evt_i;
            LK_HARD: load_o = 1'b0;
            default: load_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 16,
    parameter int BANK_W = 3,
    parameter int RANK_W = 2,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              pwrgood_n,
    input  logic              load_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [SYN_W-1:0]  syn_i,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [SYN_W-1:0]  syn_o
);
    always_ff @(posedge clk) begin
        if (!pwrgood_n) begin
            col_o  <= '0;
            row_o  <= '0;
            bank_o <= '0;
            rank_o <= '0;
            syn_o  <= '0;
        end else if (load_i) begin
            col_o  <= col_i;
            row_o  <= row_i;
            bank_o <= bank_i;
            rank_o <= rank_i;
            syn_o  <= syn_i;
        end
    end

endmodule

// File: rtl/ecc_serr_gen.sv
module ecc_serr_gen #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwrgood_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] en_i,
    input  logic         dev_en_i,
    output logic         req_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrgood_n) req_o <= 1'b0;
        else                      req_o <= dev_en_i & (|(rise_i & en_i));
    end

    // R10
    serr_gated_chk: assert property (@(posedge clk)
        disable iff (!pwrgood_n || !rst_n)
        req_o |-> $past(dev_en_i));

endmodule

// File: rtl/ecc_err_recorder.sv
module ecc_err_recorder
    import ecc_rec_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 16,
    parameter int BANK_W = 3,
    parameter int RANK_W = 2,
    parameter int SYN_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrgood_n,
    input  logic              sb_err_i,
    input  logic              mb_err_i,
    input  logic [COL_W-1:0]  err_col_i,
    input  logic [ROW_W-1:0]  err_row_i,
    input  logic [BANK_W-1:0] err_bank_i,
    input  logic [RANK_W-1:0] err_rank_i,
    input  logic [SYN_W-1:0]  err_syn_i,
    input  logic              dev_serr_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              serr_req_o
);
    localparam int BR_W = BANK_W + RANK_W;

    logic [NUM_FLAGS-1:0] evt, clr, flags, rise;
    logic [NUM_FLAGS-1:0] cmd_q;
    lock_state_e          lock_state;
    logic                 log_load;
    logic [COL_W-1:0]     log_col;
    logic [ROW_W-1:0]     log_row;
    logic [BANK_W-1:0]    log_bank;
    logic [RANK_W-1:0]    log_rank;
    logic [SYN_W-1:0]     log_syn;
    logic                 wr_status, wr_cmd;

    assign evt[FLAG_SB] = sb_err_i;
    assign evt[FLAG_MB] = mb_err_i;
    assign wr_status    = reg_we_i && (int'(reg_addr_i) == A_STATUS);
    assign wr_cmd       = reg_we_i && (int'(reg_addr_i) == A_CMD);
    assign clr          = wr_status ? reg_wdata_i[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n || !pwrgood_n) cmd_q <= '0;
        else if (wr_cmd)          cmd_q <= reg_wdata_i[NUM_FLAGS-1:0];
    end

    ecc_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk       (clk),
        .pwrgood_n (pwrgood_n),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .clr_i     (clr),
        .flag_o    (flags),
        .rise_o    (rise)
    );

    ecc_log_lock_fsm u_lock (
        .clk       (clk),
        .pwrgood_n (pwrgood_n),
        .sb_evt_i  (sb_err_i),
        .mb_evt_i  (mb_err_i),
        .sb_clr_i  (clr[FLAG_SB]),
        .mb_clr_i  (clr[FLAG_MB]),
        .sb_flag_i (flags[FLAG_SB]),
        .state_o   (lock_state),
        .load_o    (log_load)
    );

    ecc_log_store #(
        .COL_W (COL_W), .ROW_W (ROW_W), .BANK_W (BANK_W),
        .RANK_W(RANK_W), .SYN_W (SYN_W)
    ) u_log (
        .clk       (clk),
        .pwrgood_n (pwrgood_n),
        .load_i    (log_load),
        .col_i     (err_col_i),
        .row_i     (err_row_i),
        .bank_i    (err_bank_i),
        .rank_i    (err_rank_i),
        .syn_i     (err_syn_i),
        .col_o     (log_col),
        .row_o     (log_row),
        .bank_o    (log_bank),
        .rank_o    (log_rank),
        .syn_o     (log_syn)
    );

    ecc_serr_gen #(.N(NUM_FLAGS)) u_serr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrgood_n (pwrgood_n),
        .rise_i    (rise),
        .en_i      (cmd_q),
        .dev_en_i  (dev_serr_en_i),
        .req_o     (serr_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (int'(reg_addr_i))
            A_STATUS:  reg_rdata_o = 16'(flags);
            A_CMD:     reg_rdata_o = 16'(cmd_q);
            A_LOG_COL: reg_rdata_o = 16'(log_col);
            A_LOG_ROW: reg_rdata_o = 16'(log_row);
            A_LOG_BR:  reg_rdata_o = 16'({log_rank, log_bank});
            A_LOG_SYN: reg_rdata_o = 16'(log_syn);
            default:   reg_rdata_o = '0;
        endcase
    end

    logic [BR_W-1:0] log_br;
    assign log_br = {log_rank, log_bank};

    // R6
    hard_tracks_mb_chk: assert property (@(posedge clk)
        disable iff (!pwrgood_n || !rst_n)
        (lock_state == LK_HARD) == flags[FLAG_MB]);

    // R5
    soft_hold_chk: assert property (@(posedge clk)
        disable iff (!pwrgood_n || !rst_n)
        (lock_state == LK_SOFT && !mb_err_i) |=>
            ($stable(log_col) && $stable(log_row) && $stable(log_syn) && $stable(log_br)));

    // R7
    hard_freeze_chk: assert property (@(posedge clk)
        disable iff (!pwrgood_n || !rst_n)
        (lock_state == LK_HARD) |=>
            ($stable(log_col) && $stable(log_row) && $stable(log_syn) && $stable(log_br)));

endmodule

// File: tb/ecc_err_recorder_bench.sv
`timescale 1ns/1ps
module ecc_err_recorder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrgood_n = 1'b0;
    logic        sb_err = 1'b0, mb_err = 1'b0;
    logic [9:0]  col = '0;
    logic [15:0] row = '0;
    logic [2:0]  bank = '0;
    logic [1:0]  rank = '0;
    logic [7:0]  syn = '0;
    logic        dev_en = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        serr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic        serr_seen;
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    ecc_err_recorder u_ecc_err_recorder (
        .clk(clk), .rst_n(rst_n), .pwrgood_n(pwrgood_n),
        .sb_err_i(sb_err), .mb_err_i(mb_err),
        .err_col_i(col), .err_row_i(row), .err_bank_i(bank),
        .err_rank_i(rank), .err_syn_i(syn),
        .dev_serr_en_i(dev_en),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .serr_req_o(serr)
    );

    // vector: sb, mb, clr[1:0], tag[7:0], exp_flags[1:0], exp_tag[7:0], exp_serr
    localparam logic [22:0] VEC [0:15] = '{
        {1'b1,1'b0,2'b00,8'h11, 2'b01,8'h11,1'b1},
        {1'b1,1'b0,2'b00,8'h22, 2'b01,8'h11,1'b0},
        {1'b0,1'b1,2'b00,8'h33, 2'b11,8'h33,1'b1},
        {1'b1,1'b0,2'b00,8'h44, 2'b11,8'h33,1'b0},
        {1'b0,1'b1,2'b00,8'h55, 2'b11,8'h33,1'b0},
        {1'b0,1'b0,2'b01,8'h00, 2'b10,8'h33,1'b0},
        {1'b1,1'b0,2'b00,8'h66, 2'b11,8'h33,1'b1},
        {1'b0,1'b0,2'b10,8'h00, 2'b01,8'h33,1'b0},
        {1'b0,1'b1,2'b00,8'h77, 2'b11,8'h77,1'b1},
        {1'b0,1'b0,2'b11,8'h00, 2'b00,8'h77,1'b0},
        {1'b1,1'b1,2'b00,8'h88, 2'b11,8'h88,1'b1},
        {1'b0,1'b1,2'b00,8'h99, 2'b11,8'h88,1'b0},
        {1'b0,1'b1,2'b10,8'hAA, 2'b11,8'h88,1'b0},
        {1'b0,1'b0,2'b11,8'h00, 2'b00,8'h88,1'b0},
        {1'b1,1'b0,2'b01,8'hBB, 2'b01,8'hBB,1'b1},
        {1'b1,1'b0,2'b01,8'hCC, 2'b01,8'hBB,1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wrreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic step(input logic s, input logic m, input logic [1:0] c, input logic [7:0] tag);
        @(negedge clk);
        sb_err = s; mb_err = m;
        col = 10'(tag); row = {tag, tag}; bank = tag[2:0]; rank = tag[1:0]; syn = tag;
        addr = 3'd0; we = |c; wdata = 16'(c);
        @(negedge clk);
        serr_seen = serr;
        sb_err = 1'b0; mb_err = 1'b0; we = 1'b0; wdata = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        pwrgood_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(3'd0, rd); chk("R1 status", rd, 16'h0);
        rdreg(3'd1, rd); chk("R1 cmd", rd, 16'h0);
        rdreg(3'd2, rd); chk("R1 col", rd, 16'h0);
        rdreg(3'd5, rd); chk("R1 syn", rd, 16'h0);
        chk("R1 serr", 16'(serr), 16'h0);

        // R11 command register width
        wrreg(3'd1, 16'hFFFF);
        rdreg(3'd1, rd); chk("R11 cmd bits", rd, 16'h0003);

        // R10 command bits off: no message
        wrreg(3'd1, 16'h0000);
        dev_en = 1'b1;
        step(1'b1, 1'b0, 2'b00, 8'h12);
        chk("R10 cmd off", 16'(serr_seen), 16'h0);
        rdreg(3'd0, rd); chk("R4 flag set", rd, 16'h0001);
        rdreg(3'd4, rd); chk("R11 bank rank", rd, 16'h0012);
        rdreg(3'd3, rd); chk("R4 row", rd, 16'h1212);

        // R2 write 0 has no effect
        wrreg(3'd0, 16'h0000);
        rdreg(3'd0, rd); chk("R2 write zero", rd, 16'h0001);

        // R3 warm reset keeps flags/log, clears cmd
        wrreg(3'd1, 16'h0003);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rdreg(3'd0, rd); chk("R3 flags kept", rd, 16'h0001);
        rdreg(3'd2, rd); chk("R3 log kept", rd, 16'h0012);
        rdreg(3'd1, rd); chk("R3 cmd cleared", rd, 16'h0000);

        // R11 log read-only, unmapped address
        wrreg(3'd2, 16'hFFFF);
        rdreg(3'd2, rd); chk("R11 log readonly", rd, 16'h0012);
        rdreg(3'd7, rd); chk("R11 unmapped", rd, 16'h0000);

        // R10 device enable off: no message
        wrreg(3'd0, 16'h0003);
        rdreg(3'd0, rd); chk("R2 clear", rd, 16'h0000);
        wrreg(3'd1, 16'h0003);
        dev_en = 1'b0;
        step(1'b1, 1'b0, 2'b00, 8'h05);
        chk("R10 dev off", 16'(serr_seen), 16'h0);
        wrreg(3'd0, 16'h0003);
        dev_en = 1'b1;

        // vector table: R4..R10 lock sequences
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][22], VEC[i][21], VEC[i][20:19], VEC[i][18:11]);
            chk($sformatf("R10 serr vec%0d", i), 16'(serr_seen), 16'(VEC[i][0]));
            rdreg(3'd0, rd);
            chk($sformatf("R7 R8 R9 flags vec%0d", i), rd, 16'(VEC[i][10:9]));
            rdreg(3'd2, rd);
            chk($sformatf("R5 R6 col vec%0d", i), rd, 16'(VEC[i][8:1]));
            rdreg(3'd5, rd);
            chk($sformatf("R6 syn vec%0d", i), rd, 16'(VEC[i][8:1]));
            @(negedge clk);
            chk($sformatf("R10 pulse width vec%0d", i), 16'(serr), 16'h0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule